// File: doc/BRIEF.md
# GPIO Pin Drive and Detect Resolver

This block resolves the electrical state of every pin of a general-purpose I/O port. Each pin has a configuration word, an output data bit, and an external stimulus made of a "driven" flag and a level. From these it works out three things:

- whether the pin's output driver is really active, which depends on the direction bit, the drive-mode field and the output level;
- the level the pin presents;
- the value latched into the pin's input register.

The block also flags pins where an outside source fights the local driver. It raises one shared sense line when any enabled pin sees its chosen input level. For each pin it pulses a strobe when the reported (driven, level) pair changes.

Register storage for the configuration and output words, and any bus access, live outside this block. All outputs are registered and appear one clock after the inputs that cause them. The input register holds its value whenever nothing resolves the pin.

Top module: `gpio_pad_resolver`

## Requirements
- R1: While `rst` is high at a clock edge, every output (`drv_en`, `pad_lvl`, `in_reg`, `short_flag`, `detect`, `chg_stb`) is cleared to 0 on that edge, whatever the other inputs are.
- R2: The drive mode is configuration bits 10:8. Modes 0–3 enable the driver unconditionally. Modes 4 and 5 enable it only while the output bit is 1. Modes 6 and 7 enable it only while the output bit is 0. The driver is never enabled unless the direction bit (configuration bit 0) is 1.
- R3: The pull field is configuration bits 3:2. Value 1 pulls to 0, value 3 pulls to 1, and values 0 and 2 mean no pull.
- R4: With the input buffer off (configuration bit 1 = 1), an enabled pull loads its value into the input bit and the external stimulus has no effect. With no pull enabled, the input bit keeps its value.
- R5: With the input buffer on and the pin externally driven, the input bit takes the external level.
- R6: With the input buffer on and no external drive, an enabled pull acts as the driver when the output driver is off. The reported pair then becomes (1, pull value). Whenever the resolved pair has driven = 1, the input bit takes the resolved level. Otherwise the input bit holds its value.
- R7: `short_flag` for a pin is 1 only when its input buffer is on, the pin is externally driven, its output driver is enabled, and the external level differs from the output bit.
- R8: The sense field is configuration bits 17:16. Value 2 matches an externally driven level of 1, and value 3 matches a level of 0, on pins whose input buffer is on. `detect` is the OR of the matches over all pins.
- R9: `chg_stb` for a pin is 1 for exactly the cycle in which its reported (driven, level) pair differs from the pair reported the cycle before. The level is the output bit, or the pull value when the pull drives the pin.
- R10: Every output reflects the inputs present at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_flat | input | NPINS*CFG_W | Per-pin configuration words; pin p occupies bits p*CFG_W +: CFG_W |
| out_bits | input | NPINS | Output data bit per pin |
| ext_valid | input | NPINS | 1 when an outside source drives the pin |
| ext_level | input | NPINS | Level of the outside source |
| drv_en | output | NPINS | Reported driven flag per pin |
| pad_lvl | output | NPINS | Reported level per pin |
| in_reg | output | NPINS | Input register |
| short_flag | output | NPINS | Driver contention per pin |
| detect | output | 1 | Shared level-sense line |
| chg_stb | output | NPINS | One-cycle pulse when a pin's reported pair changes |

## Verification
The drive-mode sweep runs every mode value against both output levels, with the direction bit set and then cleared. This separates the unconditional, high-only and low-only driver groups from the direction gate.

Pull patterns use up, down and the reserved code on pins with the buffer on and off. They distinguish a pull that loads the input, one that drives the pin, and one that only holds state.

External-drive patterns cover pins whose local driver agrees, disagrees or is disabled, and sense codes 2 and 3 against both levels. This separates true contention and sense hits from the cases that merely look similar. Repeating a vector unchanged shows that the change strobe reacts to transitions and not to levels.

// File: rtl/gpio_res_pkg.sv
package gpio_res_pkg;

  // Configuration field positions (decoded per pin)
  localparam int DIR_BIT   = 0;
  localparam int INOFF_BIT = 1;
  localparam int PULL_LSB  = 2;
  localparam int DRV_LSB   = 8;
  localparam int SENSE_LSB = 16;
  localparam int MIN_CFG_W = 18;

  typedef enum logic [1:0] {
    PULL_NONE = 2'd0,
    PULL_DOWN = 2'd1,
    PULL_RSVD = 2'd2,
    PULL_UP   = 2'd3
  } pull_e;

  typedef enum logic [1:0] {
    SENSE_OFF  = 2'd0,
    SENSE_RSVD = 2'd1,
    SENSE_HIGH = 2'd2,
    SENSE_LOW  = 2'd3
  } sense_e;

  // Combinational resolution result of one pin
  typedef struct packed {
    logic drv;     // reported driven flag
    logic lvl;     // reported level
    logic in_upd;  // input bit is loaded this cycle
    logic in_val;  // value to load
    logic shrt;    // contention
    logic det;     // sense hit
  } pin_res_t;

endpackage

// File: rtl/gpio_drive_gate.sv
module gpio_drive_gate (
  input  logic       dir_en,
  input  logic [2:0] mode,
  input  logic       out_bit,
  output logic       drv_on
);

  logic gate;

  always_comb begin
    unique case (mode[2:1])
      2'b00, 2'b01: gate = 1'b1;      // always on
      2'b10:        gate = out_bit;   // on only while driving high
      default:      gate = ~out_bit;  // on only while driving low
    endcase
    drv_on = dir_en & gate;
  end

endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
  import gpio_res_pkg::*;
#(
  parameter int CFG_W = 32
) (
  input  logic [CFG_W-1:0] cfg,
  input  logic             out_bit,
  input  logic             ext_valid,
  input  logic             ext_level,
  output pin_res_t         res
);

  logic   drv_on;
  pull_e  pull_sel;
  sense_e sense_sel;
  logic   has_pull;
  logic   pull_val;
  logic   r_drv;
  logic   r_lvl;

  gpio_drive_gate u_gate (
    .dir_en (cfg[DIR_BIT]),
    .mode   (cfg[DRV_LSB +: 3]),
    .out_bit(out_bit),
    .drv_on (drv_on)
  );

  always_comb begin
    pull_sel  = pull_e'(cfg[PULL_LSB +: 2]);
    sense_sel = sense_e'(cfg[SENSE_LSB +: 2]);
    has_pull  = (pull_sel == PULL_DOWN) || (pull_sel == PULL_UP);
    pull_val  = (pull_sel == PULL_UP);

    r_drv      = drv_on;
    r_lvl      = out_bit;
    res        = '0;

    if (cfg[INOFF_BIT]) begin
      // Buffer isolated: pull (if any) sets the input, stimulus ignored
      if (has_pull) begin
        res.in_upd = 1'b1;
        res.in_val = pull_val;
      end
    end else if (ext_valid) begin
      res.in_upd = 1'b1;
      res.in_val = ext_level;
      res.shrt   = drv_on & (ext_level ^ out_bit);
      res.det    = ((sense_sel == SENSE_HIGH) &  ext_level) |
                   ((sense_sel == SENSE_LOW)  & ~ext_level);
    end else begin
      // Floating pin: pull takes over when the driver is off
      if (has_pull && !drv_on) begin
        r_drv = 1'b1;
        r_lvl = pull_val;
      end
      if (r_drv) begin
        res.in_upd = 1'b1;
        res.in_val = r_lvl;
      end
    end

    res.drv = r_drv;
    res.lvl = r_lvl;
  end

endmodule

// File: rtl/gpio_detect_or.sv
module gpio_detect_or #(
  parameter int N = 32
) (
  input  logic [N-1:0] hits,
  output logic         any
);

  localparam int LVLS = $clog2(N) + 1;
  localparam int W    = 1 << (LVLS - 1);

  // Balanced OR tree over a power-of-two padded vector
  logic [LVLS-1:0][W-1:0] stage;

  assign stage[0] = {{(W - N){1'b0}}, hits};

  for (genvar l = 1; l < LVLS; l++) begin : g_lvl
    for (genvar k = 0; k < W; k++) begin : g_node
      if (k < (W >> l)) begin : g_or
        assign stage[l][k] = stage[l-1][2*k] | stage[l-1][2*k+1];
      end else begin : g_pad
        assign stage[l][k] = 1'b0;
      end
    end
  end

  assign any = stage[LVLS-1][0];

endmodule

// File: rtl/gpio_pad_resolver.sv
module gpio_pad_resolver
  import gpio_res_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int CFG_W = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NPINS*CFG_W-1:0] cfg_flat,
  input  logic [NPINS-1:0]       out_bits,
  input  logic [NPINS-1:0]       ext_valid,
  input  logic [NPINS-1:0]       ext_level,
  output logic [NPINS-1:0]       drv_en,
  output logic [NPINS-1:0]       pad_lvl,
  output logic [NPINS-1:0]       in_reg,
  output logic [NPINS-1:0]       short_flag,
  output logic                   detect,
  output logic [NPINS-1:0]       chg_stb
);

  logic [NPINS-1:0] drv_c, lvl_c, upd_c, val_c, sh_c, det_c;
  logic             det_any;

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    pin_res_t r;

    gpio_pin_cell #(.CFG_W(CFG_W)) u_cell (
      .cfg      (cfg_flat[p*CFG_W +: CFG_W]),
      .out_bit  (out_bits[p]),
      .ext_valid(ext_valid[p]),
      .ext_level(ext_level[p]),
      .res      (r)
    );

    assign drv_c[p] = r.drv;
    assign lvl_c[p] = r.lvl;
    assign upd_c[p] = r.in_upd;
    assign val_c[p] = r.in_val;
    assign sh_c[p]  = r.shrt;
    assign det_c[p] = r.det;
  end

  gpio_detect_or #(.N(NPINS)) u_det (
    .hits(det_c),
    .any (det_any)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      drv_en     <= '0;
      pad_lvl    <= '0;
      in_reg     <= '0;
      short_flag <= '0;
      detect     <= 1'b0;
      chg_stb    <= '0;
    end else begin
      drv_en     <= drv_c;
      pad_lvl    <= lvl_c;
      chg_stb    <= (drv_c ^ drv_en) | (lvl_c ^ pad_lvl);
      in_reg     <= (in_reg & ~upd_c) | (val_c & upd_c);
      short_flag <= sh_c;
      detect     <= det_any;
    end
  end

endmodule

// File: rtl/gpio_pad_resolver_chk.sv
module gpio_pad_resolver_chk
  import gpio_res_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int CFG_W = 32
) (
  input logic                   clk,
  input logic                   rst,
  input logic [NPINS*CFG_W-1:0] cfg_flat,
  input logic [NPINS-1:0]       ext_valid,
  input logic [NPINS-1:0]       ext_level,
  input logic [NPINS-1:0]       drv_en,
  input logic [NPINS-1:0]       pad_lvl,
  input logic [NPINS-1:0]       in_reg,
  input logic [NPINS-1:0]       short_flag,
  input logic                   detect,
  input logic [NPINS-1:0]       chg_stb
);

  logic [NPINS-1:0] inoff_v, pull_on_v, pull_up_v;
  logic             live_q;

  for (genvar p = 0; p < NPINS; p++) begin : g_f
    assign inoff_v[p]   = cfg_flat[p*CFG_W + INOFF_BIT];
    assign pull_on_v[p] = cfg_flat[p*CFG_W + PULL_LSB];
    assign pull_up_v[p] = cfg_flat[p*CFG_W + PULL_LSB + 1];
  end

  always_ff @(posedge clk) begin
    if (rst) live_q <= 1'b0;
    else     live_q <= 1'b1;
  end

  // R9
  strobe_needs_change_chk: assert property (@(posedge clk) disable iff (rst)
    live_q |-> ((chg_stb & ~((drv_en ^ $past(drv_en)) | (pad_lvl ^ $past(pad_lvl)))) == '0));

  // R9
  change_needs_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    live_q |-> ((((drv_en ^ $past(drv_en)) | (pad_lvl ^ $past(pad_lvl))) & ~chg_stb) == '0));

  // R7
  short_needs_driver_chk: assert property (@(posedge clk) disable iff (rst)
    (short_flag & ~drv_en) == '0);

  // R7
  short_needs_mismatch_chk: assert property (@(posedge clk) disable iff (rst)
    live_q |-> ((short_flag & ~($past(ext_level) ^ pad_lvl)) == '0));

  // R8
  detect_needs_stimulus_chk: assert property (@(posedge clk) disable iff (rst)
    (live_q && detect) |-> ($past(ext_valid & ~inoff_v) != '0));

  // R5
  input_follows_ext_chk: assert property (@(posedge clk) disable iff (rst)
    live_q |-> (((in_reg ^ $past(ext_level)) & $past(ext_valid & ~inoff_v)) == '0));

  // R4
  isolated_pull_load_chk: assert property (@(posedge clk) disable iff (rst)
    live_q |-> (((in_reg ^ $past(pull_up_v)) & $past(inoff_v & pull_on_v)) == '0));

endmodule

bind gpio_pad_resolver gpio_pad_resolver_chk #(.NPINS(NPINS), .CFG_W(CFG_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cfg_flat  (cfg_flat),
  .ext_valid (ext_valid),
  .ext_level (ext_level),
  .drv_en    (drv_en),
  .pad_lvl   (pad_lvl),
  .in_reg    (in_reg),
  .short_flag(short_flag),
  .detect    (detect),
  .chg_stb   (chg_stb)
);

// File: tb/gpio_pad_resolver_test.sv
module gpio_pad_resolver_test;

  localparam int NP = 32;
  localparam int CW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;  // 200 MHz

  logic [NP*CW-1:0] cfg_d;
  logic [NP-1:0]    out_d, ev_d, el_d;
  logic [NP-1:0]    drv_en, pad_lvl, in_reg, short_flag, chg_stb;
  logic             detect;

  gpio_pad_resolver #(.NPINS(NP), .CFG_W(CW)) uut (
    .clk(clk), .rst(rst), .cfg_flat(cfg_d), .out_bits(out_d),
    .ext_valid(ev_d), .ext_level(el_d), .drv_en(drv_en), .pad_lvl(pad_lvl),
    .in_reg(in_reg), .short_flag(short_flag), .detect(detect), .chg_stb(chg_stb)
  );

  typedef struct {
    logic [NP-1:0] drv, lvl, inr, sh, stb;
    logic          det;
    int            due;
    string         tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  int   cyc = 0;
  logic done = 1'b0;

  // staged stimulus and reference state
  logic [NP*CW-1:0] s_cfg;
  logic [NP-1:0]    s_out, s_ev, s_el;
  logic [NP-1:0]    m_in, m_drv, m_lvl;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [CW-1:0] mk(input logic dir, input logic inoff,
      input logic [1:0] pull, input logic [2:0] dmode, input logic [1:0] sense);
    logic [CW-1:0] c = '0;
    c[0] = dir; c[1] = inoff; c[3:2] = pull; c[10:8] = dmode; c[17:16] = sense;
    return c;
  endfunction

  task automatic set_cfg(input int p, input logic [CW-1:0] c);
    s_cfg[p*CW +: CW] = c;
  endtask

  task automatic apply(input string tag);
    exp_t e;
    @(negedge clk);
    cfg_d = s_cfg; out_d = s_out; ev_d = s_ev; el_d = s_el;
    e.det = 1'b0;
    for (int p = 0; p < NP; p++) begin
      logic [CW-1:0] c;
      logic o, ev, el, con, hp, pv, d, l, sh, dt;
      logic [2:0] dm;
      c = s_cfg[p*CW +: CW];
      o = s_out[p]; ev = s_ev[p]; el = s_el[p];
      dm = c[10:8];
      con = c[0] && ((dm < 3'd4) || ((dm < 3'd6) ? o : !o));
      hp = (c[3:2] == 2'd1) || (c[3:2] == 2'd3);
      pv = (c[3:2] == 2'd3);
      d = con; l = o; sh = 1'b0; dt = 1'b0;
      if (c[1]) begin
        if (hp) m_in[p] = pv;
      end else if (ev) begin
        m_in[p] = el;
        sh = con && (el != o);
        dt = ((c[17:16] == 2'd2) && el) || ((c[17:16] == 2'd3) && !el);
      end else begin
        if (hp && !con) begin d = 1'b1; l = pv; end
        if (d) m_in[p] = l;
      end
      e.stb[p] = (d != m_drv[p]) || (l != m_lvl[p]);
      m_drv[p] = d; m_lvl[p] = l;
      e.drv[p] = d; e.lvl[p] = l; e.sh[p] = sh;
      e.det = e.det | dt;
    end
    e.inr = m_in;
    e.due = cyc + 1;
    e.tag = tag;
    q.push_back(e);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (q.size() > 0 && q[0].due == cyc) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (drv_en !== e.drv || pad_lvl !== e.lvl || in_reg !== e.inr ||
          short_flag !== e.sh || detect !== e.det || chg_stb !== e.stb) begin
        errors++;
        $display("FAIL %s: got drv=%h lvl=%h in=%h sh=%h det=%b stb=%h exp drv=%h lvl=%h in=%h sh=%h det=%b stb=%h",
                 e.tag, drv_en, pad_lvl, in_reg, short_flag, detect, chg_stb,
                 e.drv, e.lvl, e.inr, e.sh, e.det, e.stb);
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // reset with hostile inputs: everything must stay clear (R1)
    cfg_d = '1; out_d = '1; ev_d = '1; el_d = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if ({drv_en, pad_lvl, in_reg, short_flag, detect, chg_stb} !== '0) begin
      errors++;
      $display("FAIL R1: got drv=%h lvl=%h in=%h sh=%h det=%b stb=%h exp all 0",
               drv_en, pad_lvl, in_reg, short_flag, detect, chg_stb);
    end
    for (int p = 0; p < NP; p++) set_cfg(p, mk(1'b0, 1'b1, 2'd0, 3'd0, 2'd0));
    s_out = '0; s_ev = '0; s_el = '0;
    m_in = '0; m_drv = '0; m_lvl = '0;
    cfg_d = s_cfg; out_d = s_out; ev_d = s_ev; el_d = s_el;
    rst = 1'b0;

    // R2 drive-mode sweep, pin 0 with direction set, pin 1 with it clear
    for (int d = 0; d < 8; d++) begin
      for (int o = 0; o < 2; o++) begin
        set_cfg(0, mk(1'b1, 1'b1, 2'd0, 3'(d), 2'd0));
        set_cfg(1, mk(1'b0, 1'b1, 2'd0, 3'(d), 2'd0));
        s_out[0] = 1'(o); s_out[1] = 1'(o);
        apply("R2 drive mode / R9 strobe");
      end
    end

    // R3/R4 isolated buffer with pulls; stimulus must be ignored
    set_cfg(2, mk(1'b0, 1'b1, 2'd3, 3'd0, 2'd0));
    set_cfg(3, mk(1'b0, 1'b1, 2'd1, 3'd0, 2'd0));
    s_ev[3:2] = 2'b11; s_el[3:2] = 2'b10;
    apply("R3 R4 isolated pull up/down");
    set_cfg(4, mk(1'b0, 1'b0, 2'd0, 3'd0, 2'd0));
    s_ev[4] = 1'b1; s_el[4] = 1'b1;
    apply("R5 load pin 4 from stimulus");
    set_cfg(4, mk(1'b0, 1'b1, 2'd2, 3'd0, 2'd0));
    s_el[4] = 1'b0;
    apply("R3 R4 code 2 is no pull, input holds");

    // R5/R10 buffer on, externally driven pattern
    for (int p = 8; p < 16; p++) set_cfg(p, mk(1'b0, 1'b0, 2'd1, 3'd0, 2'd0));
    s_ev[15:8] = 8'hFF; s_el[15:8] = 8'hA5;
    apply("R5 R10 input follows stimulus");
    s_el[15:8] = 8'h3C;
    apply("R5 R10 second pattern");

    // R6 floating pins
    set_cfg(6, mk(1'b0, 1'b0, 2'd3, 3'd0, 2'd0));
    set_cfg(7, mk(1'b1, 1'b0, 2'd1, 3'd0, 2'd0)); s_out[7] = 1'b1;
    set_cfg(9, mk(1'b0, 1'b0, 2'd0, 3'd0, 2'd0)); s_ev[9] = 1'b0;
    apply("R6 pull drives / driver wins / hold");
    set_cfg(6, mk(1'b0, 1'b0, 2'd1, 3'd0, 2'd0));
    apply("R6 pull-down drives floating pin");

    // R7 contention
    set_cfg(10, mk(1'b1, 1'b0, 2'd0, 3'd0, 2'd0));
    s_out[10] = 1'b1; s_ev[10] = 1'b1; s_el[10] = 1'b0;
    apply("R7 short on mismatch");
    s_el[10] = 1'b1;
    apply("R7 no short when levels agree");
    set_cfg(10, mk(1'b1, 1'b0, 2'd0, 3'd4, 2'd0));
    s_out[10] = 1'b0;
    apply("R7 no short when driver gated off");
    set_cfg(10, mk(1'b1, 1'b1, 2'd0, 3'd0, 2'd0));
    s_out[10] = 1'b1; s_el[10] = 1'b0;
    apply("R7 no short with buffer isolated");

    // R8 sense
    set_cfg(31, mk(1'b0, 1'b0, 2'd0, 3'd0, 2'd2));
    s_ev[31] = 1'b1; s_el[31] = 1'b1;
    apply("R8 sense high hit");
    set_cfg(31, mk(1'b0, 1'b0, 2'd0, 3'd0, 2'd3));
    apply("R8 sense low, no hit");
    s_el[31] = 1'b0;
    apply("R8 sense low hit");
    set_cfg(31, mk(1'b0, 1'b1, 2'd0, 3'd0, 2'd3));
    apply("R8 isolated buffer, no hit");

    // R9 unchanged vector: no strobes
    apply("R9 repeat, strobes quiet");
    apply("R9 repeat again");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule